// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed accumulator as two 32-bit halves, a high half and a low half. Each accepted operation multiplies two signed operands and adds the product into the accumulator. There are two operation kinds. The long kind multiplies the full 32-bit operands. The word kind multiplies only the sign-extended low 16 bits of each operand. A saturation-enable input, sampled together with the operation, chooses how the sum is clamped. The clamping rule is different for the long kind and for the word kind.

Operations enter through a valid/ready handshake. An operation is accepted on a rising edge where `op_valid` and `op_ready` are both high. `op_ready` is low for exactly one cycle after each acceptance, while the accumulate stage runs. The source must hold its operands only while it waits for `op_ready`. Anything it presents while `op_ready` is low is dropped. The result side has no back-pressure. `done` pulses for one cycle in the cycle in which the updated accumulator first appears on the outputs. Software, or the owning pipeline, can also load either half directly through its own write-enable and data pins.

Top module: `mac_unit`

## Requirements
- R1: After reset both accumulator halves read zero, `op_ready` is 1 and `done` is 0.
- R2: A long operation (`op_sel`=0) with `sat_en`=0 writes the signed product of the two full 32-bit operands plus the accumulator {acc_hi, acc_lo}, wrapped modulo 2^64.
- R3: A word operation (`op_sel`=1) uses only bits 15:0 of each operand as signed values. Bits 31:16 have no effect on the result.
- R4: A long operation with `sat_en`=1 writes the sum's low 32 bits to acc_lo. If the 64-bit sum is negative, acc_hi becomes the sum's high word ORed with 0xFFFF0000. Otherwise acc_hi becomes the sum's high word ANDed with 0x00007FFF.
- R5: A word operation with `sat_en`=1 whose sum is less than -2^31 leaves acc_hi=0x00000001 and acc_lo=0x80000000.
- R6: A word operation with `sat_en`=1 whose sum is greater than 2^31-1 leaves acc_hi=0x00000001 and acc_lo=0x7FFFFFFF. A sum within [-2^31, 2^31-1] is written unmodified as 64 bits.
- R7: For an operation accepted at rising edge k, the accumulator changes at edge k+1. `done` is 1 for exactly the cycle after edge k+1.
- R8: `op_ready` is 0 in the cycle after an acceptance. An `op_valid` presented while `op_ready` is 0 is ignored.
- R9: A high-half or low-half write enable loads its data at the next edge. In the accumulate cycle, a direct write wins for its own half, and the other half still takes the accumulate result.
- R10: Without a direct write and outside the accumulate cycle, each half holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request valid |
| op_ready | output | 1 | Unit can accept an operation this cycle |
| op_sel | input | 1 | 0 = long 32x32, 1 = word 16x16 |
| sat_en | input | 1 | Saturation mode for this operation |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| hi_wr_en | input | 1 | Direct load of high half |
| hi_wr_data | input | 32 | Data for high-half load |
| lo_wr_en | input | 1 | Direct load of low half |
| lo_wr_data | input | 32 | Data for low-half load |
| acc_hi | output | 32 | Accumulator high half |
| acc_lo | output | 32 | Accumulator low half |
| done | output | 1 | One-cycle pulse when the accumulator has been updated |

## Verification
The hardest case to produce is a direct half write that lands in the single accumulate cycle. That cycle lasts one clock, and a write there must override only its own half. The stimulus accepts an operation, then raises the high-half write enable at the following falling edge, so the write and the accumulate land on the same rising edge. The other hard case is a start that is ignored. The stimulus holds `op_valid` high across the busy cycle with different operands, and then checks that the accumulator contains only the first result.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    MAC_LONG = 1'b0,
    MAC_WORD = 1'b1
  } mac_op_e;
endpackage

// File: rtl/mac_prod_stage.sv
// First stage: forms the signed product for the selected operation kind and
// registers it with the kind and saturation mode.
module mac_prod_stage
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  mac_op_e         op,
  input  logic            sat,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [2*W-1:0]  prod_q,
  output mac_op_e         op_q,
  output logic            sat_q,
  output logic            pend_q
);
  localparam int H  = W / 2;
  localparam int PW = 2 * W;
  localparam int HW = 2 * H;

  logic signed [PW-1:0] long_p;
  logic signed [HW-1:0] word_p;
  logic        [PW-1:0] word_ext;

  always_comb begin
    long_p   = $signed(a) * $signed(b);
    word_p   = $signed(a[H-1:0]) * $signed(b[H-1:0]);
    word_ext = {{(PW-HW){word_p[HW-1]}}, word_p};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      prod_q <= '0;
      op_q   <= MAC_LONG;
      sat_q  <= 1'b0;
    end else begin
      pend_q <= take;
      if (take) begin
        prod_q <= (op == MAC_WORD) ? word_ext : long_p;
        op_q   <= op;
        sat_q  <= sat;
      end
    end
  end
endmodule

// File: rtl/mac_accum_sat.sv
// Second stage (combinational): adds the product to the accumulator and
// applies the clamp that belongs to the operation kind.
module mac_accum_sat
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] acc_in,
  input  logic [2*W-1:0] prod,
  input  mac_op_e        op,
  input  logic           sat,
  output logic [2*W-1:0] acc_out
);
  localparam int H = W / 2;
  localparam logic [W-1:0] HI_KEEP  = {{(H+1){1'b0}}, {(H-1){1'b1}}};
  localparam logic [W-1:0] HI_FORCE = {{H{1'b1}}, {H{1'b0}}};
  localparam logic [W-1:0] LO_MIN   = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] LO_MAX   = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MARK     = W'(1);

  logic [2*W-1:0] sum;
  logic [W-1:0]   sum_hi;
  logic           neg_ovf;
  logic           pos_ovf;

  always_comb begin
    sum     = acc_in + prod;
    sum_hi  = sum[2*W-1:W];
    neg_ovf = sum[2*W-1] & ~(&sum[2*W-1:W-1]);
    pos_ovf = ~sum[2*W-1] & (|sum[2*W-2:W-1]);
    acc_out = sum;
    if (sat) begin
      if (op == MAC_LONG) begin
        acc_out[2*W-1:W] = sum[2*W-1] ? (sum_hi | HI_FORCE) : (sum_hi & HI_KEEP);
      end else if (neg_ovf) begin
        acc_out = {MARK, LO_MIN};
      end else if (pos_ovf) begin
        acc_out = {MARK, LO_MAX};
      end
    end
  end
endmodule

// File: rtl/mac_acc_reg.sv
// Accumulator storage: one register per half. A direct write has priority
// over the accumulate update for that half only.
module mac_acc_reg #(
  parameter int W = 32,
  parameter int N_HALF = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic [N_HALF*W-1:0]      upd_val,
  input  logic [N_HALF-1:0]        wr_en,
  input  logic [N_HALF-1:0][W-1:0] wr_data,
  output logic [N_HALF-1:0][W-1:0] acc_q
);
  for (genvar i = 0; i < N_HALF; i++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q[i] <= '0;
      end else if (wr_en[i]) begin
        acc_q[i] <= wr_data[i];
      end else if (upd) begin
        acc_q[i] <= upd_val[i*W +: W];
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic         op_sel,
  input  logic         sat_en,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         hi_wr_en,
  input  logic [W-1:0] hi_wr_data,
  input  logic         lo_wr_en,
  input  logic [W-1:0] lo_wr_data,
  output logic [W-1:0] acc_hi,
  output logic [W-1:0] acc_lo,
  output logic         done
);
  localparam int AW = 2 * W;

  logic               take;
  logic [AW-1:0]      prod_q;
  mac_op_e            op_q;
  logic               sat_q;
  logic               pend_q;
  logic [AW-1:0]      next_acc;
  logic [1:0][W-1:0]  acc_q;
  logic [1:0]         wr_en;
  logic [1:0][W-1:0]  wr_data;
  logic               done_q;

  assign op_ready = ~pend_q;
  assign take     = op_valid & op_ready;
  assign wr_en    = {hi_wr_en, lo_wr_en};
  assign wr_data  = {hi_wr_data, lo_wr_data};

  mac_prod_stage #(.W(W)) u_prod (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .op     (mac_op_e'(op_sel)),
    .sat    (sat_en),
    .a      (opnd_a),
    .b      (opnd_b),
    .prod_q (prod_q),
    .op_q   (op_q),
    .sat_q  (sat_q),
    .pend_q (pend_q)
  );

  mac_accum_sat #(.W(W)) u_sat (
    .acc_in  ({acc_q[1], acc_q[0]}),
    .prod    (prod_q),
    .op      (op_q),
    .sat     (sat_q),
    .acc_out (next_acc)
  );

  mac_acc_reg #(.W(W), .N_HALF(2)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (pend_q),
    .upd_val (next_acc),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .acc_q   (acc_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= pend_q;
  end

  assign done   = done_q;
  assign acc_hi = acc_q[1];
  assign acc_lo = acc_q[0];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_ready,
  input logic         hi_wr_en,
  input logic [W-1:0] hi_wr_data,
  input logic         lo_wr_en,
  input logic [W-1:0] lo_wr_data,
  input logic [W-1:0] acc_hi,
  input logic [W-1:0] acc_lo,
  input logic         done
);
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> !op_ready);

  p_done_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> ##1 done);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_wr_en && op_ready) |=> $stable(acc_hi));

  p_hold_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_wr_en && op_ready) |=> $stable(acc_lo));

  p_write_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr_en |=> (acc_hi == $past(hi_wr_data)));

  p_write_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_en |=> (acc_lo == $past(lo_wr_data)));
endmodule

bind mac_unit mac_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .hi_wr_en   (hi_wr_en),
  .hi_wr_data (hi_wr_data),
  .lo_wr_en   (lo_wr_en),
  .lo_wr_data (lo_wr_data),
  .acc_hi     (acc_hi),
  .acc_lo     (acc_lo),
  .done       (done)
);

// File: tb/mac_unit_test.sv
module mac_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic        op_sel = 1'b0;
  logic        sat_en = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        hi_wr_en = 1'b0;
  logic [31:0] hi_wr_data = '0;
  logic        lo_wr_en = 1'b0;
  logic [31:0] lo_wr_data = '0;
  logic [31:0] acc_hi;
  logic [31:0] acc_lo;
  logic        done;

  int n_checks = 0;
  int n_fail = 0;
  logic [63:0] model_acc = '0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  mac_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_sel(op_sel), .sat_en(sat_en), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data), .lo_wr_en(lo_wr_en),
    .lo_wr_data(lo_wr_data), .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] acc, input bit word, input bit sat,
                                        input logic [31:0] a, input logic [31:0] b);
    longint p;
    longint s;
    logic [63:0] u;
    if (word) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
    else      p = longint'($signed(a)) * longint'($signed(b));
    s = longint'(acc) + p;
    u = s;
    if (sat && !word) begin
      if (s < 0) return {u[63:32] | 32'hFFFF0000, u[31:0]};
      return {u[63:32] & 32'h00007FFF, u[31:0]};
    end
    if (sat && word) begin
      if (s < -64'sd2147483648) return {32'd1, 32'h80000000};
      if (s > 64'sd2147483647)  return {32'd1, 32'h7FFFFFFF};
    end
    return u;
  endfunction

  // Scoreboard monitor: every done pulse pops one expected accumulator value.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected done", {acc_hi, acc_lo}, 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({acc_hi, acc_lo} == e, t, {acc_hi, acc_lo}, e);
      end
    end
  end

  task automatic issue(input bit word, input bit sat, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    model_acc = model(model_acc, word, sat, a, b);
    exp_q.push_back(model_acc);
    tag_q.push_back(tag);
    @(negedge clk);
    op_valid = 1'b1; op_sel = word; sat_en = sat; opnd_a = a; opnd_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    chk(op_ready == 1'b0, "R8 ready low in busy cycle", {63'd0, op_ready}, 64'd0);
    chk(done == 1'b0, "R7 done not yet", {63'd0, done}, 64'd0);
    @(negedge clk);
    chk(done == 1'b1, "R7 done after accumulate", {63'd0, done}, 64'd1);
  endtask

  task automatic wr(input bit he, input logic [31:0] hd, input bit le, input logic [31:0] ld);
    @(negedge clk);
    hi_wr_en = he; hi_wr_data = hd; lo_wr_en = le; lo_wr_data = ld;
    @(negedge clk);
    hi_wr_en = 1'b0; lo_wr_en = 1'b0;
    if (he) model_acc[63:32] = hd;
    if (le) model_acc[31:0] = ld;
    chk({acc_hi, acc_lo} == model_acc, "R9 direct write", {acc_hi, acc_lo}, model_acc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({acc_hi, acc_lo} == 64'd0, "R1 reset acc", {acc_hi, acc_lo}, 64'd0);
    chk(op_ready == 1'b1, "R1 reset ready", {63'd0, op_ready}, 64'd1);
    chk(done == 1'b0, "R1 reset done", {63'd0, done}, 64'd0);

    issue(1'b0, 1'b0, 32'd3, 32'd5, "R2 long positive");
    issue(1'b0, 1'b0, -32'sd7, 32'd100000, "R2 long negative");
    wr(1'b1, 32'h7FFFFFFF, 1'b1, 32'hFFFFFFFF);
    issue(1'b0, 1'b0, 32'd1, 32'd1, "R2 long wrap");

    wr(1'b1, 32'd0, 1'b1, 32'd0);
    issue(1'b1, 1'b0, 32'hABCDFFFE, 32'h12340003, "R3 word ignores upper bits");

    wr(1'b1, 32'h00012345, 1'b1, 32'd0);
    issue(1'b0, 1'b1, 32'd2, 32'd3, "R4 long sat positive mask");
    wr(1'b1, 32'h80001234, 1'b1, 32'd0);
    issue(1'b0, 1'b1, 32'd1, 32'd1, "R4 long sat negative force");

    wr(1'b1, 32'd0, 1'b1, 32'h7FFFFFF0);
    issue(1'b1, 1'b1, 32'd100, 32'd1, "R6 word sat upper clamp");
    wr(1'b1, 32'd0, 1'b1, 32'd0);
    issue(1'b1, 1'b1, 32'h00007FFF, 32'h00007FFF, "R6 word sat in range");

    wr(1'b1, 32'hFFFFFFFF, 1'b1, 32'h80000005);
    issue(1'b1, 1'b1, 32'h0000FFF6, 32'd1, "R5 word sat lower clamp");

    // R8: start held through the busy cycle with other operands is ignored
    wr(1'b1, 32'd0, 1'b1, 32'd0);
    model_acc = model(model_acc, 1'b0, 1'b0, 32'd9, 32'd9);
    exp_q.push_back(model_acc);
    tag_q.push_back("R8 first op result");
    @(negedge clk);
    op_valid = 1'b1; op_sel = 1'b0; sat_en = 1'b0; opnd_a = 32'd9; opnd_b = 32'd9;
    @(negedge clk);
    chk(op_ready == 1'b0, "R8 ready low", {63'd0, op_ready}, 64'd0);
    opnd_a = 32'd1000; opnd_b = 32'd1000;
    @(negedge clk);
    op_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk({acc_hi, acc_lo} == model_acc, "R8 busy start ignored", {acc_hi, acc_lo}, model_acc);
    chk(done == 1'b0, "R8 no second done", {63'd0, done}, 64'd0);

    // R9: high-half write collides with the accumulate cycle
    begin
      logic [63:0] s;
      s = model(model_acc, 1'b0, 1'b0, 32'd4, 32'd4);
      model_acc = {32'hCAFE0001, s[31:0]};
      exp_q.push_back(model_acc);
      tag_q.push_back("R9 write wins over accumulate");
      @(negedge clk);
      op_valid = 1'b1; op_sel = 1'b0; sat_en = 1'b0; opnd_a = 32'd4; opnd_b = 32'd4;
      @(negedge clk);
      op_valid = 1'b0; hi_wr_en = 1'b1; hi_wr_data = 32'hCAFE0001;
      @(negedge clk);
      hi_wr_en = 1'b0;
    end

    // R10: low-only write leaves high half, idle holds both
    wr(1'b0, 32'd0, 1'b1, 32'h13572468);
    repeat (4) @(negedge clk);
    chk({acc_hi, acc_lo} == model_acc, "R10 idle hold", {acc_hi, acc_lo}, model_acc);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all results seen", 64'(exp_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule